// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is the clocked address and command register of a memory module. On each rising clock edge it captures a data bus and three control lines: chip select, on-die termination enable and clock enable. It drives registered copies of them toward the memory devices. The data lanes load only when at least one of two active-low select inputs is low at the edge. When both are high, the data outputs keep their previous contents. The three control outputs register on every edge, whatever the select state.

A strap chooses the lane fan-out. In single mode, each of the 25 inputs drives one output. In double mode, each of the low 14 inputs drives two outputs, at positions i and i+14. The strap is taken only while reset is held, and later changes of the pin have no effect. A parity bit travels with the data. One edge after a loaded transfer, an error flag reports whether the active data bits and the parity bit have odd parity.

There is no valid/ready handshake and no back-pressure. The block accepts a new word on every clock edge and cannot stall. A word is held only because the select condition said so.

Top module: `cmd_reg_buffer`

## Requirements
- R1: While `rst_n` is low, `dout`, `cs_out`, `odt_out`, `cke_out` and `par_err` are all 0. Assertion of reset clears them at once, without waiting for a clock edge.
- R2: Outputs change only at a rising edge of `clk`. Input changes between edges leave every output unchanged.
- R3: At a rising edge where `sel_a_n` is 0 or `sel_b_n` is 0, `dout` takes the mapped value of `din`.
- R4: At a rising edge where `sel_a_n` and `sel_b_n` are both 1, `dout` keeps its previous value.
- R5: At every rising edge, `cs_out`, `odt_out` and `cke_out` take the values of `sel_a_n`, `odt_in` and `cke_in`.
- R6: In single mode (strap 0), `dout[i]` = `din[i]` for i in 0..24, and `dout[27:25]` are 0.
- R7: In double mode (strap 1), `dout[i]` = `dout[i+14]` = `din[i]` for i in 0..13, and `din[24:14]` have no effect on any output.
- R8: The strap is sampled at rising edges while reset is low. After reset is released, a change of `strap_dual` does not change the lane mapping.
- R9: After a loaded edge, the next edge sets `par_err` to the XOR of `par_in` and the active `din` bits captured at the load. The active bits are bits 0..24 in single mode and 0..13 in double mode. Without a preceding load, `par_err` holds its value.
- R10: The first rising edge after reset is released registers data and controls normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register samples on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous on assertion |
| strap_dual | input | 1 | Fan-out strap: 0 single, 1 double; sampled during reset |
| sel_a_n | input | 1 | Primary active-low chip select, also forwarded to `cs_out` |
| sel_b_n | input | 1 | Secondary active-low select that also enables a data load |
| din | input | 25 | Address/command data inputs |
| odt_in | input | 1 | On-die termination control input |
| cke_in | input | 1 | Clock enable control input |
| par_in | input | 1 | Parity bit accompanying `din` |
| dout | output | 28 | Registered data outputs |
| cs_out | output | 1 | Registered chip select |
| odt_out | output | 1 | Registered on-die termination control |
| cke_out | output | 1 | Registered clock enable |
| par_err | output | 1 | Registered parity error flag |

## Verification
The bench builds the block at its default widths: 25 inputs, 14 inputs in double mode, and 28 outputs. At this size a walking one can cover every input lane in both fan-out modes. It also makes every output position observable, including the three spare bits that single mode ties low. Under the walk and a long pseudo-random run, the four select combinations rotate, so loads and holds interleave with both correct and corrupted parity. Reset is applied in the middle of a cycle, and the strap pin is flipped after release, to reach the asynchronous clear and the ignored strap.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

  typedef enum logic {
    FANOUT_SINGLE = 1'b0,
    FANOUT_DOUBLE = 1'b1
  } fanout_e;

  function automatic int unsigned out_width(int unsigned in_w, int unsigned half_w);
    return (in_w > 2 * half_w) ? in_w : 2 * half_w;
  endfunction

endpackage

// File: rtl/cmdbuf_mode_strap.sv
module cmdbuf_mode_strap
  import cmdbuf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strap_dual,
  output fanout_e mode
);

  fanout_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= fanout_e'(strap_dual);
    end
  end

  assign mode = mode_q;

  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));

endmodule

// File: rtl/cmdbuf_lane_map.sv
module cmdbuf_lane_map
  import cmdbuf_pkg::*;
#(
  parameter int IN_W   = 25,
  parameter int HALF_W = 14,
  parameter int OUT_W  = 28
) (
  input  fanout_e          mode,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] mapped,
  output logic [OUT_W-1:0] active_mask
);

  for (genvar j = 0; j < OUT_W; j++) begin : g_lane
    logic single_bit;
    logic double_bit;
    logic single_act;
    logic double_act;

    if (j < IN_W) begin : g_single_used
      assign single_bit = din[j];
      assign single_act = 1'b1;
    end else begin : g_single_spare
      assign single_bit = 1'b0;
      assign single_act = 1'b0;
    end

    if (j < HALF_W) begin : g_double_low
      assign double_bit = din[j];
      assign double_act = 1'b1;
    end else if (j < 2 * HALF_W) begin : g_double_copy
      assign double_bit = din[j-HALF_W];
      assign double_act = 1'b0;
    end else begin : g_double_spare
      assign double_bit = 1'b0;
      assign double_act = 1'b0;
    end

    always_comb begin
      if (mode == FANOUT_DOUBLE) begin
        mapped[j]      = double_bit;
        active_mask[j] = double_act;
      end else begin
        mapped[j]      = single_bit;
        active_mask[j] = single_act;
      end
    end
  end

endmodule

// File: rtl/cmdbuf_data_stage.sv
module cmdbuf_data_stage #(
  parameter int OUT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] mapped,
  input  logic [OUT_W-1:0] active_mask,
  input  logic             par_in,
  output logic [OUT_W-1:0] dout,
  output logic             par_err
);

  logic [OUT_W-1:0] dout_q;
  logic             par_q;
  logic             loaded_q;
  logic             err_q;
  logic             odd_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      par_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= load;
      if (load) begin
        dout_q <= mapped;
        par_q  <= par_in;
      end
    end
  end

  assign odd_now = (^(dout_q & active_mask)) ^ par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (loaded_q) begin
      err_q <= odd_now;
    end
  end

  assign dout    = dout_q;
  assign par_err = err_q;

  a_r4_hold_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout_q));

  a_r9_err_holds_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_q |=> $stable(err_q));

endmodule

// File: rtl/cmdbuf_ctrl_stage.sv
module cmdbuf_ctrl_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_in,
  input  logic odt_in,
  input  logic cke_in,
  output logic cs_out,
  output logic odt_out,
  output logic cke_out
);

  logic [2:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 3'b000;
    end else begin
      ctrl_q <= {cke_in, odt_in, cs_in};
    end
  end

  assign cs_out  = ctrl_q[0];
  assign odt_out = ctrl_q[1];
  assign cke_out = ctrl_q[2];

endmodule

// File: rtl/cmd_reg_buffer.sv
module cmd_reg_buffer
  import cmdbuf_pkg::*;
#(
  parameter int  IN_W   = 25,
  parameter int  HALF_W = 14,
  localparam int OUT_W  = int'(out_width(IN_W, HALF_W))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_dual,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic [IN_W-1:0]  din,
  input  logic             odt_in,
  input  logic             cke_in,
  input  logic             par_in,
  output logic [OUT_W-1:0] dout,
  output logic             cs_out,
  output logic             odt_out,
  output logic             cke_out,
  output logic             par_err
);

  fanout_e          mode;
  logic [OUT_W-1:0] mapped;
  logic [OUT_W-1:0] active_mask;
  logic             load;

  assign load = !sel_a_n || !sel_b_n;

  cmdbuf_mode_strap u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_dual (strap_dual),
    .mode       (mode)
  );

  cmdbuf_lane_map #(
    .IN_W   (IN_W),
    .HALF_W (HALF_W),
    .OUT_W  (OUT_W)
  ) u_map (
    .mode        (mode),
    .din         (din),
    .mapped      (mapped),
    .active_mask (active_mask)
  );

  cmdbuf_data_stage #(
    .OUT_W (OUT_W)
  ) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .mapped      (mapped),
    .active_mask (active_mask),
    .par_in      (par_in),
    .dout        (dout),
    .par_err     (par_err)
  );

  cmdbuf_ctrl_stage u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_in   (sel_a_n),
    .odt_in  (odt_in),
    .cke_in  (cke_in),
    .cs_out  (cs_out),
    .odt_out (odt_out),
    .cke_out (cke_out)
  );

  a_r3_load_low_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n || !sel_b_n) |=> dout[HALF_W-1:0] == $past(din[HALF_W-1:0]));

  a_r5_ctrl_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cs_out == $past(sel_a_n)) && (odt_out == $past(odt_in))
              && (cke_out == $past(cke_in)));

  a_r7_double_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FANOUT_DOUBLE) |-> dout[HALF_W-1:0] == dout[2*HALF_W-1:HALF_W]);

  if (OUT_W > IN_W) begin : g_spare_chk
    a_r6_spare_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == FANOUT_SINGLE) |-> dout[OUT_W-1:IN_W] == '0);
  end

endmodule

// File: tb/cmd_reg_buffer_test.sv
`timescale 1ns/1ps
module cmd_reg_buffer_test;

  localparam int IN_W  = 25;
  localparam int HALF  = 14;
  localparam int OUT_W = 28;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             strap_dual = 1'b0;
  logic             sel_a_n = 1'b1;
  logic             sel_b_n = 1'b1;
  logic [IN_W-1:0]  din = '0;
  logic             odt_in = 1'b0;
  logic             cke_in = 1'b0;
  logic             par_in = 1'b0;
  logic [OUT_W-1:0] dout;
  logic             cs_out, odt_out, cke_out, par_err;

  int checks = 0;
  int fails  = 0;

  logic [OUT_W-1:0] e_dout;
  logic             e_cs, e_odt, e_cke, e_err, e_par, e_loaded;
  logic             e_dual;
  logic [31:0]      rng = 32'h1234_5678;

  always #10 clk = ~clk;

  cmd_reg_buffer uut (
    .clk(clk), .rst_n(rst_n), .strap_dual(strap_dual),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .din(din),
    .odt_in(odt_in), .cke_in(cke_in), .par_in(par_in),
    .dout(dout), .cs_out(cs_out), .odt_out(odt_out),
    .cke_out(cke_out), .par_err(par_err)
  );

  function automatic logic [OUT_W-1:0] expect_map(logic [IN_W-1:0] d, logic dual);
    logic [OUT_W-1:0] r = '0;
    if (dual) begin
      r[HALF-1:0]      = d[HALF-1:0];
      r[2*HALF-1:HALF] = d[HALF-1:0];
    end else begin
      r[IN_W-1:0] = d;
    end
    return r;
  endfunction

  function automatic logic active_xor(logic [IN_W-1:0] d, logic dual);
    return dual ? ^d[HALF-1:0] : ^d;
  endfunction

  task automatic chk(string tag, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string dtag);
    chk(dtag, dout, e_dout);
    chk("R5 cs_out", {27'd0, cs_out}, {27'd0, e_cs});
    chk("R5 odt_out", {27'd0, odt_out}, {27'd0, e_odt});
    chk("R5 cke_out", {27'd0, cke_out}, {27'd0, e_cke});
    chk("R9 par_err", {27'd0, par_err}, {27'd0, e_err});
  endtask

  task automatic clear_model();
    e_dout = '0; e_cs = 0; e_odt = 0; e_cke = 0;
    e_err = 0; e_par = 0; e_loaded = 0;
  endtask

  // R1 R8 R10: reset with strap, then flip the strap pin after release
  task automatic do_reset(logic dual);
    @(negedge clk);
    #2 rst_n = 1'b0;
    strap_dual = dual;
    clear_model();
    #1 check_all("R1 reset dout");
    repeat (3) @(negedge clk);
    check_all("R1 reset held");
    rst_n = 1'b1;
    e_dual = dual;
    #1 strap_dual = ~dual;
  endtask

  // drive one cycle (called just after a falling edge)
  task automatic step(logic [IN_W-1:0] d, logic a, logic b, logic o, logic c, logic p);
    logic load;
    string tag;
    din = d; sel_a_n = a; sel_b_n = b; odt_in = o; cke_in = c; par_in = p;
    #5 check_all("R2 between edges");
    @(posedge clk);
    load = !a || !b;
    e_err    = e_loaded ? (active_xor(e_dout[IN_W-1:0], e_dual) ^ e_par) : e_err;
    e_loaded = load;
    if (load) begin
      e_dout = expect_map(d, e_dual);
      e_par  = p;
    end
    e_cs = a; e_odt = o; e_cke = c;
    @(negedge clk);
    #1;
    if (!load) tag = "R4 hold";
    else if (e_dual) tag = "R3/R7 double";
    else tag = "R3/R6 single";
    check_all(tag);
  endtask

  task automatic next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    e_dual = 0;
    clear_model();
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      // R10: first edge after release loads
      step(25'h0AB_CDEF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      // walking one across every input lane
      for (int k = 0; k < IN_W; k++) begin
        logic [IN_W-1:0] d = 25'd1 << k;
        logic p = active_xor(d, m[0]) ^ ((k % 3) == 0);
        step(d, k[0], k[1], k[2], k[3], p);
      end
      // pseudo-random run with rotating selects
      for (int n = 0; n < 150; n++) begin
        logic [IN_W-1:0] d;
        next_rng();
        d = rng[IN_W-1:0];
        step(d, rng[27], rng[28], rng[29], rng[30],
             active_xor(d, m[0]) ^ rng[31]);
      end
      // R1: asynchronous clear in the middle of a cycle
      step({IN_W{1'b1}}, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      #3 rst_n = 1'b0;
      clear_model();
      #1 check_all("R1 async clear");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule